// File: doc/BRIEF.md
# Register Width Mode Controller

This block keeps the operating-mode state of an 8/16-bit processor core together with its accumulator, two index registers, stack pointer and direct-page base. It carries out decoded micro-operations one per clock: swapping carry with a hidden emulation flag, setting or clearing status bits from an immediate mask, register-to-register transfers, an accumulator byte swap, and a write-back load from the execution path. Each operation applies the width rules that follow from the current mode.

Run-time width switching is asymmetric. Narrowing the accumulator keeps its upper byte as a hidden byte that a later widening brings back. Narrowing the index registers destroys their upper bytes. In any transfer between registers of unequal width, the destination width decides how many bytes move. Emulation mode pins both widths to 8 bits and pins the stack to a fixed page.

An operation is accepted on a rising clock edge while `opValid` is high. Its results are visible on the outputs from that edge onward.

Top module: `regwidth_mode_ctrl`

## Requirements
- R1: After reset, `emuOut`=1, `statusOut`=0x34, `accOut`=0, `xOut`=`yOut`=0, `spOut`=0x0100, `dpOut`=0.
- R2: Operation code 1 (exchange) loads the emulation flag from carry (status bit 0) and loads carry from the old emulation flag, in one step.
- R3: While in emulation mode, status bits 5 and 4 read 1, `spOut[15:8]` is 0x01, and the index upper bytes are 0. Clearing bits 5 and 4 in emulation has no effect.
- R4: Operation 2 ORs `opMask` into the status byte. Operation 3 clears each status bit whose mask bit is 1. Either may change any flag.
- R5: Status bit 5 = 1 gives an 8-bit accumulator (`accWide`=0). Narrowing keeps `accOut[15:8]`, so a later widening returns the full earlier value.
- R6: Status bit 4 = 1 gives 8-bit index registers (`idxWide`=0). Setting it forces `xOut[15:8]` and `yOut[15:8]` to 0.
- R7: Operations 5 and 6 copy the accumulator to X or Y. With 16-bit index they copy all 16 bits whatever the accumulator width; with 8-bit index they copy the low byte and the upper byte becomes 0.
- R8: Operations 7 and 8 copy X or Y to the accumulator. With an 8-bit accumulator only the low byte is written and the upper byte is unchanged; with a 16-bit accumulator all 16 bits are written.
- R9: Operations 11 (acc→SP), 12 (SP→acc), 13 (acc→direct page) and 14 (direct page→acc) move 16 bits regardless of bit 5. In emulation, operation 11 writes only the stack pointer low byte.
- R10: Operation 9 (X→SP) writes all 16 bits of X in native mode, so an 8-bit X yields SP upper byte 0; in emulation it writes the low byte only. Operation 10 (SP→X) follows the index width.
- R11: Operation 4 swaps `accOut` halves, then sets N (bit 7) from bit 7 of the new low byte and Z (bit 1) if the new low byte is 0. It works in both modes.
- R12: Operation 15 loads `ldData`: `ldDst` 0 = accumulator (low byte only when 8-bit), 1 = X, 2 = Y (low byte with upper byte 0 when 8-bit), 3 = direct page (16 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe |
| opCode | input | 4 | Micro-operation code |
| opMask | input | 8 | Immediate status mask |
| ldDst | input | 2 | Load destination select |
| ldData | input | 16 | Load value |
| accOut | output | 16 | Accumulator, upper byte is hidden byte |
| xOut | output | 16 | Index X |
| yOut | output | 16 | Index Y |
| spOut | output | 16 | Stack pointer |
| dpOut | output | 16 | Direct-page base |
| statusOut | output | 8 | Status byte |
| emuOut | output | 1 | Emulation mode flag |
| accWide | output | 1 | Accumulator is 16 bits |
| idxWide | output | 1 | Index registers are 16 bits |

## Verification
Every operation code is applied in five modes: emulation, and native with each of the four width pairs. Each run uses four data patterns, among them all-zero and all-ones. Native-mode patterns with distinct upper and lower bytes show whether a transfer moved one byte or two, and whether a hidden byte survived. Running the same operations in emulation separates the forced stack page and forced widths from native behaviour. Directed sequences narrow and widen each register class to expose the asymmetric survival of upper bytes.

// File: rtl/rwm_pkg.sv
package rwm_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,  OP_XCE  = 4'd1,  OP_SETP = 4'd2,  OP_CLRP = 4'd3,
    OP_SWAP = 4'd4,  OP_A2X  = 4'd5,  OP_A2Y  = 4'd6,  OP_X2A  = 4'd7,
    OP_Y2A  = 4'd8,  OP_X2S  = 4'd9,  OP_S2X  = 4'd10, OP_C2S  = 4'd11,
    OP_S2C  = 4'd12, OP_C2D  = 4'd13, OP_D2C  = 4'd14, OP_LOAD = 4'd15
  } op_e;

  typedef struct packed {
    logic       act;
    op_e        op;
    logic [1:0] dst;
    logic       emu;
    logic       m8;
    logic       x8;
    logic       nxtEmu;
    logic       nxtX8;
  } dpCtl_t;
endpackage

// File: rtl/rwm_ctrl.sv
module rwm_ctrl
  import rwm_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_STATUS = 8'h34
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [BYTE_W-1:0] opMask,
  input  logic [1:0]        ldDst,
  input  logic [WORD_W-1:0] accIn,
  output dpCtl_t            ctl,
  output logic [BYTE_W-1:0] status,
  output logic              emu
);
  localparam int M_BIT = 5;
  localparam int X_BIT = 4;
  localparam int N_BIT = 7;
  localparam int Z_BIT = 1;
  localparam int C_BIT = 0;

  logic              emuQ, nxtEmu;
  logic [BYTE_W-1:0] statQ, nxtStat;
  op_e               op;

  assign op = op_e'(opCode);

  always_comb begin
    nxtEmu  = emuQ;
    nxtStat = statQ;
    if (opValid) begin
      case (op)
        OP_XCE: begin
          nxtEmu         = statQ[C_BIT];
          nxtStat[C_BIT] = emuQ;
        end
        OP_SETP: nxtStat = statQ | opMask;
        OP_CLRP: nxtStat = statQ & ~opMask;
        OP_SWAP: begin
          nxtStat[N_BIT] = accIn[WORD_W-1];
          nxtStat[Z_BIT] = (accIn[WORD_W-1:BYTE_W] == '0);
        end
        default: ;
      endcase
    end
    if (nxtEmu) begin
      nxtStat[M_BIT] = 1'b1;
      nxtStat[X_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emuQ  <= 1'b1;
      statQ <= RESET_STATUS | (8'h1 << M_BIT) | (8'h1 << X_BIT);
    end else begin
      emuQ  <= nxtEmu;
      statQ <= nxtStat;
    end
  end

  always_comb begin
    ctl.act    = opValid;
    ctl.op     = op;
    ctl.dst    = ldDst;
    ctl.emu    = emuQ;
    ctl.m8     = statQ[M_BIT];
    ctl.x8     = statQ[X_BIT];
    ctl.nxtEmu = nxtEmu;
    ctl.nxtX8  = nxtStat[X_BIT];
  end

  assign status = statQ;
  assign emu    = emuQ;
endmodule

// File: rtl/rwm_datapath.sv
module rwm_datapath
  import rwm_pkg::*;
#(
  parameter logic [BYTE_W-1:0] STACK_PAGE = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [WORD_W-1:0] ldData,
  output logic [WORD_W-1:0] acc,
  output logic [WORD_W-1:0] idxX,
  output logic [WORD_W-1:0] idxY,
  output logic [WORD_W-1:0] sp,
  output logic [WORD_W-1:0] dp
);
  localparam int HI = WORD_W - 1;
  localparam int LO = BYTE_W - 1;

  logic [WORD_W-1:0] accQ, xQ, yQ, spQ, dpQ;
  logic [WORD_W-1:0] nA, nX, nY, nS, nD;

  // Index-width fit: an 8-bit destination keeps the low byte only.
  function automatic logic [WORD_W-1:0] fitIdx(input logic narrow,
                                               input logic [WORD_W-1:0] v);
    return narrow ? {{BYTE_W{1'b0}}, v[LO:0]} : v;
  endfunction

  always_comb begin
    nA = accQ; nX = xQ; nY = yQ; nS = spQ; nD = dpQ;
    if (ctl.act) begin
      case (ctl.op)
        OP_SWAP: nA = {accQ[LO:0], accQ[HI:BYTE_W]};
        OP_A2X:  nX = fitIdx(ctl.x8, accQ);
        OP_A2Y:  nY = fitIdx(ctl.x8, accQ);
        OP_X2A:  nA = ctl.m8 ? {accQ[HI:BYTE_W], xQ[LO:0]} : xQ;
        OP_Y2A:  nA = ctl.m8 ? {accQ[HI:BYTE_W], yQ[LO:0]} : yQ;
        OP_X2S:  nS = ctl.emu ? {STACK_PAGE, xQ[LO:0]} : xQ;
        OP_S2X:  nX = fitIdx(ctl.x8, spQ);
        OP_C2S:  nS = ctl.emu ? {STACK_PAGE, accQ[LO:0]} : accQ;
        OP_S2C:  nA = spQ;
        OP_C2D:  nD = accQ;
        OP_D2C:  nA = dpQ;
        OP_LOAD: begin
          case (ctl.dst)
            2'd0:    nA = ctl.m8 ? {accQ[HI:BYTE_W], ldData[LO:0]} : ldData;
            2'd1:    nX = fitIdx(ctl.x8, ldData);
            2'd2:    nY = fitIdx(ctl.x8, ldData);
            default: nD = ldData;
          endcase
        end
        default: ;
      endcase
    end
    if (ctl.nxtX8) begin
      nX[HI:BYTE_W] = '0;
      nY[HI:BYTE_W] = '0;
    end
    if (ctl.nxtEmu) nS[HI:BYTE_W] = STACK_PAGE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ <= '0;
      xQ   <= '0;
      yQ   <= '0;
      spQ  <= {STACK_PAGE, {BYTE_W{1'b0}}};
      dpQ  <= '0;
    end else begin
      accQ <= nA;
      xQ   <= nX;
      yQ   <= nY;
      spQ  <= nS;
      dpQ  <= nD;
    end
  end

  assign acc  = accQ;
  assign idxX = xQ;
  assign idxY = yQ;
  assign sp   = spQ;
  assign dp   = dpQ;
endmodule

// File: rtl/regwidth_mode_ctrl.sv
module regwidth_mode_ctrl
  import rwm_pkg::*;
#(
  parameter logic [7:0] RESET_STATUS = 8'h34,
  parameter logic [7:0] STACK_PAGE   = 8'h01
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [3:0]  opCode,
  input  logic [7:0]  opMask,
  input  logic [1:0]  ldDst,
  input  logic [15:0] ldData,
  output logic [15:0] accOut,
  output logic [15:0] xOut,
  output logic [15:0] yOut,
  output logic [15:0] spOut,
  output logic [15:0] dpOut,
  output logic [7:0]  statusOut,
  output logic        emuOut,
  output logic        accWide,
  output logic        idxWide
);
  dpCtl_t ctl;

  rwm_ctrl #(.RESET_STATUS(RESET_STATUS)) ctrl_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opMask(opMask), .ldDst(ldDst), .accIn(accOut), .ctl(ctl),
    .status(statusOut), .emu(emuOut)
  );

  rwm_datapath #(.STACK_PAGE(STACK_PAGE)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ldData(ldData),
    .acc(accOut), .idxX(xOut), .idxY(yOut), .sp(spOut), .dp(dpOut)
  );

  assign accWide = ~statusOut[5];
  assign idxWide = ~statusOut[4];
endmodule

// File: rtl/rwm_checker.sv
module rwm_checker (
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [3:0]  opCode,
  input logic [7:0]  opMask,
  input logic [15:0] accOut,
  input logic [15:0] xOut,
  input logic [15:0] yOut,
  input logic [15:0] spOut,
  input logic [7:0]  statusOut,
  input logic        emuOut
);
  // R2
  xce_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == 4'd1 |=>
      emuOut == $past(statusOut[0]) && statusOut[0] == $past(emuOut));

  // R3
  emu_pinned_chk: assert property (@(posedge clk) disable iff (!rstN)
    emuOut |-> statusOut[5:4] == 2'b11 && spOut[15:8] == 8'h01);

  // R4
  set_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == 4'd2 |=> (statusOut & $past(opMask)) == $past(opMask));

  // R4
  clr_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == 4'd3 && !emuOut |=> (statusOut & $past(opMask)) == 8'h00);

  // R5
  acc_narrow_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == 4'd2 |=> accOut == $past(accOut));

  // R6
  idx_hi_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[4] |-> xOut[15:8] == 8'h00 && yOut[15:8] == 8'h00);

  // R11
  swap_halves_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opCode == 4'd4 |=>
      accOut == {$past(accOut[7:0]), $past(accOut[15:8])});
endmodule

bind regwidth_mode_ctrl rwm_checker chk_i (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opMask(opMask),
  .accOut(accOut), .xOut(xOut), .yOut(yOut), .spOut(spOut),
  .statusOut(statusOut), .emuOut(emuOut)
);

// File: tb/regwidth_mode_ctrl_tb.sv
`timescale 1ns/1ps
module regwidth_mode_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [7:0]  opMask = '0;
  logic [1:0]  ldDst = '0;
  logic [15:0] ldData = '0;
  logic [15:0] accOut, xOut, yOut, spOut, dpOut;
  logic [7:0]  statusOut;
  logic        emuOut, accWide, idxWide;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench-side expected state
  logic        mE;
  logic [7:0]  mP;
  logic [15:0] mC, mX, mY, mS, mD;

  always #10 clk = ~clk;

  regwidth_mode_ctrl dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opMask(opMask),
    .ldDst(ldDst), .ldData(ldData), .accOut(accOut), .xOut(xOut), .yOut(yOut),
    .spOut(spOut), .dpOut(dpOut), .statusOut(statusOut), .emuOut(emuOut),
    .accWide(accWide), .idxWide(idxWide)
  );

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd1: return "R2";
      4'd2, 4'd3: return "R4";
      4'd4: return "R11";
      4'd5, 4'd6: return "R7";
      4'd7, 4'd8: return "R8";
      4'd9, 4'd10: return "R10";
      4'd11, 4'd12, 4'd13, 4'd14: return "R9";
      4'd15: return "R12";
      default: return "R1";
    endcase
  endfunction

  task automatic checkVal(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    checkVal(req,
      {6'd0, accOut, xOut, yOut, spOut, dpOut, statusOut, emuOut, accWide, idxWide},
      {6'd0, mC, mX, mY, mS, mD, mP, mE, ~mP[5], ~mP[4]});
  endtask

  task automatic model(input logic [3:0] op, input logic [7:0] mask,
                       input logic [1:0] dst, input logic [15:0] dat);
    logic m8, x8, t;
    m8 = mP[5];
    x8 = mP[4];
    case (op)
      4'd1: begin t = mE; mE = mP[0]; mP[0] = t; end
      4'd2: mP = mP | mask;
      4'd3: mP = mP & ~mask;
      4'd4: begin mC = {mC[7:0], mC[15:8]}; mP[7] = mC[7]; mP[1] = (mC[7:0] == 8'h00); end
      4'd5: mX = x8 ? {8'h00, mC[7:0]} : mC;
      4'd6: mY = x8 ? {8'h00, mC[7:0]} : mC;
      4'd7: if (m8) mC[7:0] = mX[7:0]; else mC = mX;
      4'd8: if (m8) mC[7:0] = mY[7:0]; else mC = mY;
      4'd9: mS = mE ? {8'h01, mX[7:0]} : mX;
      4'd10: mX = x8 ? {8'h00, mS[7:0]} : mS;
      4'd11: mS = mE ? {8'h01, mC[7:0]} : mC;
      4'd12: mC = mS;
      4'd13: mD = mC;
      4'd14: mC = mD;
      4'd15: case (dst)
        2'd0: if (m8) mC[7:0] = dat[7:0]; else mC = dat;
        2'd1: mX = x8 ? {8'h00, dat[7:0]} : dat;
        2'd2: mY = x8 ? {8'h00, dat[7:0]} : dat;
        default: mD = dat;
      endcase
      default: ;
    endcase
    if (mE) begin mP[5:4] = 2'b11; mS[15:8] = 8'h01; end
    if (mP[4]) begin mX[15:8] = 8'h00; mY[15:8] = 8'h00; end
  endtask

  // Called at a falling edge; returns at the next falling edge with outputs settled.
  task automatic step(input logic [3:0] op, input logic [7:0] mask,
                      input logic [1:0] dst, input logic [15:0] dat, input bit doCheck);
    opValid = 1'b1; opCode = op; opMask = mask; ldDst = dst; ldData = dat;
    @(negedge clk);
    opValid = 1'b0;
    model(op, mask, dst, dat);
    if (doCheck) checkAll(reqOf(op));
  endtask

  task automatic goNative();
    step(4'd3, 8'h01, 2'd0, 16'h0, 1'b1);
    step(4'd1, 8'h00, 2'd0, 16'h0, 1'b1);
  endtask

  initial begin
    logic [15:0] pats [4];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h80F1; pats[3] = 16'h3C05;
    mE = 1'b1; mP = 8'h34; mC = '0; mX = '0; mY = '0; mS = 16'h0100; mD = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // R5: accumulator narrow then widen returns the full value
    goNative();
    step(4'd3, 8'h30, 2'd0, 16'h0, 1'b1);
    step(4'd15, 8'h00, 2'd0, 16'hABCD, 1'b1);
    step(4'd2, 8'h20, 2'd0, 16'h0, 1'b1);
    checkVal("R5 narrowed", {80'd0, accOut}, {80'd0, 16'hABCD});
    step(4'd3, 8'h20, 2'd0, 16'h0, 1'b1);
    checkVal("R5 widened", {79'd0, accWide, accOut}, {79'd0, 1'b1, 16'hABCD});

    // R6: index narrowing clears both upper bytes
    step(4'd15, 8'h00, 2'd1, 16'h1234, 1'b1);
    step(4'd15, 8'h00, 2'd2, 16'h5678, 1'b1);
    step(4'd2, 8'h10, 2'd0, 16'h0, 1'b1);
    checkVal("R6", {63'd0, idxWide, xOut, yOut}, {63'd0, 1'b0, 16'h0034, 16'h0078});

    // R3: entering emulation forces widths and stack page; clears have no effect
    step(4'd3, 8'h30, 2'd0, 16'h0, 1'b1);
    step(4'd15, 8'h00, 2'd0, 16'h4477, 1'b1);
    step(4'd11, 8'h00, 2'd0, 16'h0, 1'b1);
    step(4'd2, 8'h01, 2'd0, 16'h0, 1'b1);
    step(4'd1, 8'h00, 2'd0, 16'h0, 1'b1);
    checkVal("R3 enter", {78'd0, emuOut, statusOut[5:4], spOut, xOut[15:8]},
             {78'd0, 1'b1, 2'b11, 16'h0177, 8'h00});
    step(4'd3, 8'h30, 2'd0, 16'h0, 1'b1);
    checkVal("R3 clear ignored", {94'd0, statusOut[5:4]}, {94'd0, 2'b11});

    // Sweep: 5 modes x 4 patterns x 16 operations
    for (int md = 0; md < 5; md++) begin
      for (int pi = 0; pi < 4; pi++) begin
        for (int op = 0; op < 16; op++) begin
          logic [15:0] p;
          p = pats[pi];
          if (!mE) step(4'd2, 8'h01, 2'd0, 16'h0, 1'b1);
          if (mE) goNative();
          step(4'd3, 8'h30, 2'd0, 16'h0, 1'b1);
          step(4'd15, 8'h00, 2'd0, p ^ 16'hC3C3, 1'b1);
          step(4'd11, 8'h00, 2'd0, 16'h0, 1'b1);
          step(4'd15, 8'h00, 2'd0, p, 1'b1);
          step(4'd15, 8'h00, 2'd1, p ^ 16'h5A5A, 1'b1);
          step(4'd15, 8'h00, 2'd2, ~p, 1'b1);
          step(4'd15, 8'h00, 2'd3, p + 16'h1111, 1'b1);
          if (md == 0) begin
            step(4'd2, 8'h01, 2'd0, 16'h0, 1'b1);
            step(4'd1, 8'h00, 2'd0, 16'h0, 1'b1);
          end else begin
            step(4'd2, {2'b00, md[1], md[0] ^ md[1], 4'h0} ^ 8'h00, 2'd0, 16'h0, 1'b1);
          end
          step(op[3:0], p[7:0] ^ 8'hA5, p[1:0], p ^ 16'h0F0F, 1'b1);
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule